// File: doc/BRIEF.md
# Two-Wire Controller Register Front End

This block is the byte-wide, memory-mapped register file that sits in front of a two-wire bus master controller. It decodes a 5-bit byte offset and holds the configuration, address-match and status registers. Offsets 0x10 through 0x1E, apart from 0x18 and 0x19, form a window that reaches one of two register banks. A bank-select bit in the third control register picks the bank. Each register bit follows its own write rule: plain, keep-previous, write-one-to-clear, sticky-set, or read-only.

The transaction sequencer and the receive FIFO datapath live outside this block. They report events to it as one-cycle set pulses and level flags. The block returns one-cycle strobes for start, stop, data-register write, data-register read and FIFO flush. It also folds every enabled status condition into one registered, level-sensitive interrupt, and that level can be read back through the second status register.

Top module: `twi_ctl_regs`

## Requirements
- R1: Offsets 0x10–0x17 and 0x1A–0x1E are banked by bit 5 of the third control register (offset 0x0E). Offsets 0x00–0x0E, 0x18, 0x19 and 0x1F are visible in both banks. Bank 0 holds eight match-address registers at 0x10–0x17, control 4 at 0x1A, control 5 at 0x1B, SCL low/high timing at 0x1C/0x1E and the arbitration-mode register at 0x1D. Bank 1 holds FIFO control/status at 0x10, fairness period at 0x11, TX control at 0x12, timeout at 0x14, TX status at 0x1A, RX status at 0x1C and RX control at 0x1E.
- R2: Writing 1 clears the following event flags, and writing 0 leaves them unchanged:
  - main status (0x02) bits 7, 5, 4, 3 and 2, each set by one of the event inputs: bit 2 by index 0, bit 3 by index 1, bit 4 by index 2, bit 5 by index 3, bit 7 by index 4;
  - common status (0x04) bit 1, set by the auxiliary event with index 6.
  The other common-status bits are read-only.
- R3: A write to control 1 (0x06) leaves bits 0, 1 and 4 at their stored value. Writing 1 to bit 0 gives a one-cycle start strobe, and writing 1 to bit 1 gives a one-cycle stop strobe, both in the cycle after the write.
- R4: Bits 7 and 6 of control 3 are read-only line levels. They read as 1 and ignore writes.
- R5: The version register at 0x1F reads 0x81. Writes to 0x1F and to second status (0x18) have no effect.
- R6: After reset, common status reads 0x10, control 3 reads 0xC0, control 4 reads 0x07, timeout reads 0x3F and RX control reads 0x01. Every other register reads 0x00.
- R7: The interrupt is raised only while control 1 bit 2 is set. With that bit set, any of these conditions raises it:
  - bus error (status bit 5), negative acknowledge (bit 4) or data-ready (bit 6);
  - no-match (bit 2) with control 1 bit 6;
  - end-of-busy (0x19 bit 7, auxiliary event 0) with control 1 bit 3;
  - RX threshold (RX status bit 6, auxiliary event 1) with RX control bit 6;
  - TX threshold (TX status bit 6, auxiliary event 2) with TX control bit 6;
  - FIFO empty/full (FIFO status bit 1, auxiliary event 3) with FIFO status bit 3.
  Second status bit 7 reads the interrupt level.
- R8: Timeout (0x14) bit 7 is set by auxiliary event 5. A write keeps it at 1 only when the written bit 7 is 0 and the stored bit 7 is 1; otherwise it becomes 0. Bits 6:0 are plain.
- R9: In the arbitration-mode register (0x1D), bit 0 is a read-only copy of the external busy input. Bit 1 is set by auxiliary event 4 and cleared only by writing 1. Bits 7:2 are plain.
- R10: RX control bit 5 is set by writing 1 and keeps its value when 0 is written. The other RX control bits are plain.
- R11: The interrupt output is registered. It changes one cycle after the stored flag or enable change that causes it.
- R12: A read from an undecoded offset returns 0x00, and a write to it changes no register.
- R13: When a hardware set pulse and a software write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R14: A write to the data register (0x00) gives a one-cycle write strobe and presents the written byte. A read of 0x00 returns the external receive byte and gives a one-cycle read strobe. Writing 1 to FIFO status bit 6 gives a one-cycle flush strobe, and that bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| addr | input | 5 | Byte offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |
| irq | output | 1 | Registered interrupt level |
| evt_st | input | 5 | Set pulses for main status flags |
| evt_aux | input | 7 | Set pulses for auxiliary flags |
| seq_lvl | input | 3 | Sequencer levels: data-ready, master mode, transmit |
| fair_busy | input | 1 | Arbitration busy level |
| rx_data | input | 8 | Receive byte returned on data reads |
| start_stb | output | 1 | Start command strobe |
| stop_stb | output | 1 | Stop command strobe |
| data_wr_stb | output | 1 | Data register written |
| data_rd_stb | output | 1 | Data register read |
| fifo_clr_stb | output | 1 | FIFO flush strobe |
| tx_data | output | 8 | Last byte written to the data register |

## Verification
A hardware set pulse and a software write-one-to-clear can land on the same flag in the same cycle. The bench provokes this by driving the no-stop event pulse together with a status write that has bit 7 set, then reads the status back and expects that bit to be still set. A second overlap is an enable write in the same stretch of cycles as a pending flag. For that case the bench samples the interrupt one cycle after the write and expects the old level, then samples again one cycle later and expects the new level.

// File: rtl/twi_regs_pkg.sv
package twi_regs_pkg;
  localparam int DW     = 8;
  localparam int AW     = 5;
  localparam int N_XADR = 8;
  localparam int N_ST   = 5;
  localparam int N_AUX  = 7;
  localparam int N_IRQ  = 8;

  // shared offsets
  localparam logic [AW-1:0] OFS_DATA  = 5'h00;
  localparam logic [AW-1:0] OFS_STAT  = 5'h02;
  localparam logic [AW-1:0] OFS_CSTAT = 5'h04;
  localparam logic [AW-1:0] OFS_CTRL1 = 5'h06;
  localparam logic [AW-1:0] OFS_ADR1  = 5'h08;
  localparam logic [AW-1:0] OFS_CTRL2 = 5'h0A;
  localparam logic [AW-1:0] OFS_ADR2  = 5'h0C;
  localparam logic [AW-1:0] OFS_CTRL3 = 5'h0E;
  localparam logic [AW-1:0] OFS_STAT2 = 5'h18;
  localparam logic [AW-1:0] OFS_STAT3 = 5'h19;
  localparam logic [AW-1:0] OFS_VER   = 5'h1F;
  // bank 0
  localparam logic [AW-1:0] OFS_CTRL4 = 5'h1A;
  localparam logic [AW-1:0] OFS_CTRL5 = 5'h1B;
  localparam logic [AW-1:0] OFS_SCLLO = 5'h1C;
  localparam logic [AW-1:0] OFS_FMODE = 5'h1D;
  localparam logic [AW-1:0] OFS_SCLHI = 5'h1E;
  // bank 1
  localparam logic [AW-1:0] OFS_FCTS  = 5'h10;
  localparam logic [AW-1:0] OFS_FPER  = 5'h11;
  localparam logic [AW-1:0] OFS_TXCTL = 5'h12;
  localparam logic [AW-1:0] OFS_TOUT  = 5'h14;
  localparam logic [AW-1:0] OFS_TXSTS = 5'h1A;
  localparam logic [AW-1:0] OFS_RXSTS = 5'h1C;
  localparam logic [AW-1:0] OFS_RXCTL = 5'h1E;

  localparam int BANK_BIT = 5;
  localparam logic [DW-1:0] CTRL1_KEEP = 8'h13;
  localparam logic [DW-1:0] VER_VAL    = 8'h81;
  localparam logic [DW-1:0] RST_CSTAT  = 8'h10;
  localparam logic [DW-1:0] RST_CTRL3  = 8'hC0;
  localparam logic [DW-1:0] RST_CTRL4  = 8'h07;
  localparam logic [DW-1:0] RST_TOUT   = 8'h3F;
  localparam logic [DW-1:0] RST_RXCTL  = 8'h01;

  // status bit each main event flag lands on
  localparam int ST_POS [N_ST] = '{2, 3, 4, 5, 7};

  // auxiliary flag indices
  localparam int AX_EOB = 0;
  localparam int AX_RXT = 1;
  localparam int AX_TXT = 2;
  localparam int AX_FFE = 3;
  localparam int AX_FRD = 4;
  localparam int AX_TMO = 5;
  localparam int AX_BBS = 6;

  typedef enum logic [4:0] {
    RID_NONE, RID_DATA, RID_STAT, RID_CSTAT, RID_CTRL1, RID_ADR1, RID_CTRL2,
    RID_ADR2, RID_CTRL3, RID_STAT2, RID_STAT3, RID_VER, RID_XADR, RID_CTRL4,
    RID_CTRL5, RID_SCLLO, RID_FMODE, RID_SCLHI, RID_FCTS, RID_FPER, RID_TXCTL,
    RID_TOUT, RID_TXSTS, RID_RXSTS, RID_RXCTL
  } reg_id_e;
endpackage

// File: rtl/twi_rdec.sv
module twi_rdec
  import twi_regs_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          bank,
  output reg_id_e       rid,
  output logic [2:0]    xidx
);
  assign xidx = addr[2:0];

  always_comb begin
    rid = RID_NONE;
    case (addr)
      OFS_DATA:  rid = RID_DATA;
      OFS_STAT:  rid = RID_STAT;
      OFS_CSTAT: rid = RID_CSTAT;
      OFS_CTRL1: rid = RID_CTRL1;
      OFS_ADR1:  rid = RID_ADR1;
      OFS_CTRL2: rid = RID_CTRL2;
      OFS_ADR2:  rid = RID_ADR2;
      OFS_CTRL3: rid = RID_CTRL3;
      OFS_STAT2: rid = RID_STAT2;
      OFS_STAT3: rid = RID_STAT3;
      OFS_VER:   rid = RID_VER;
      default: begin
        if (addr[4] && !bank) begin
          if (!addr[3]) rid = RID_XADR;
          else begin
            case (addr)
              OFS_CTRL4: rid = RID_CTRL4;
              OFS_CTRL5: rid = RID_CTRL5;
              OFS_SCLLO: rid = RID_SCLLO;
              OFS_FMODE: rid = RID_FMODE;
              OFS_SCLHI: rid = RID_SCLHI;
              default:   rid = RID_NONE;
            endcase
          end
        end else if (addr[4]) begin
          case (addr)
            OFS_FCTS:  rid = RID_FCTS;
            OFS_FPER:  rid = RID_FPER;
            OFS_TXCTL: rid = RID_TXCTL;
            OFS_TOUT:  rid = RID_TOUT;
            OFS_TXSTS: rid = RID_TXSTS;
            OFS_RXSTS: rid = RID_RXSTS;
            OFS_RXCTL: rid = RID_RXCTL;
            default:   rid = RID_NONE;
          endcase
        end
      end
    endcase
  end
endmodule

// File: rtl/twi_flag.sv
module twi_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> q); // R13
endmodule

// File: rtl/twi_irq.sv
module twi_irq #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien,
  input  logic [N_SRC-1:0] flag_v,
  input  logic [N_SRC-1:0] en_v,
  output logic             irq
);
  logic any_src;
  assign any_src = |(flag_v & en_v);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ien & any_src;
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(ien) |-> !irq); // R7
endmodule

// File: rtl/twi_ctl_regs.sv
module twi_ctl_regs
  import twi_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic [N_ST-1:0]  evt_st,
  input  logic [N_AUX-1:0] evt_aux,
  input  logic [2:0]    seq_lvl,
  input  logic          fair_busy,
  input  logic [DW-1:0] rx_data,
  output logic          start_stb,
  output logic          stop_stb,
  output logic          data_wr_stb,
  output logic          data_rd_stb,
  output logic          fifo_clr_stb,
  output logic [DW-1:0] tx_data
);
  reg_id_e    rid;
  logic [2:0] xidx;

  logic [DW-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, ctl5_q;
  logic [DW-1:0] adr1_q, adr2_q, scllo_q, sclhi_q, fper_q, txctl_q, rxctl_q;
  logic [DW-1:0] xadr_q [N_XADR];
  logic [6:0]    tout_lo_q;
  logic [5:0]    fmode_hi_q;
  logic          fbusy_q, fcts_ie_q;
  logic [2:0]    seq_q;
  logic [N_ST-1:0]  st_flag;
  logic [N_AUX-1:0] aux_flag, aux_clr;
  logic          wsel_stat;
  logic [DW-1:0] rd_mux;

  twi_rdec u_dec (.addr(addr), .bank(ctl3_q[BANK_BIT]), .rid(rid), .xidx(xidx));

  // main status event flags
  assign wsel_stat = wr_en && (rid == RID_STAT);
  for (genvar i = 0; i < N_ST; i++) begin : g_st
    twi_flag u_f (.clk(clk), .rst(rst), .set(evt_st[i]),
                  .clr(wsel_stat & wdata[ST_POS[i]]), .q(st_flag[i]));
  end

  // auxiliary flags, each with its own clearing register and bit
  always_comb begin
    aux_clr         = '0;
    aux_clr[AX_EOB] = wr_en && (rid == RID_STAT3) && wdata[7];
    aux_clr[AX_RXT] = wr_en && (rid == RID_RXSTS) && wdata[6];
    aux_clr[AX_TXT] = wr_en && (rid == RID_TXSTS) && wdata[6];
    aux_clr[AX_FFE] = wr_en && (rid == RID_FCTS)  && wdata[1];
    aux_clr[AX_FRD] = wr_en && (rid == RID_FMODE) && wdata[1];
    aux_clr[AX_TMO] = wr_en && (rid == RID_TOUT)  && wdata[7];
    aux_clr[AX_BBS] = wr_en && (rid == RID_CSTAT) && wdata[1];
  end

  for (genvar i = 0; i < N_AUX; i++) begin : g_aux
    twi_flag u_f (.clk(clk), .rst(rst), .set(evt_aux[i]),
                  .clr(aux_clr[i]), .q(aux_flag[i]));
  end

  // bank 0 match-address registers
  for (genvar i = 0; i < N_XADR; i++) begin : g_xadr
    always_ff @(posedge clk) begin
      if (rst) xadr_q[i] <= '0;
      else if (wr_en && (rid == RID_XADR) && (xidx == i[2:0])) xadr_q[i] <= wdata;
    end
  end

  // plain and rule-based storage
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1_q <= '0; ctl2_q <= '0; ctl3_q <= RST_CTRL3; ctl4_q <= RST_CTRL4;
      ctl5_q <= '0; adr1_q <= '0; adr2_q <= '0; scllo_q <= '0; sclhi_q <= '0;
      fper_q <= '0; txctl_q <= '0; rxctl_q <= RST_RXCTL;
      tout_lo_q <= RST_TOUT[6:0]; fmode_hi_q <= '0; fcts_ie_q <= 1'b0;
      fbusy_q <= 1'b0; seq_q <= '0;
    end else begin
      fbusy_q <= fair_busy;
      seq_q   <= seq_lvl;
      if (wr_en) begin
        case (rid)
          RID_CTRL1: ctl1_q <= (wdata & ~CTRL1_KEEP) | (ctl1_q & CTRL1_KEEP);
          RID_CTRL2: ctl2_q <= wdata;
          RID_CTRL3: ctl3_q <= {ctl3_q[7:6], wdata[5:0]};
          RID_CTRL4: ctl4_q <= wdata;
          RID_CTRL5: ctl5_q <= wdata;
          RID_ADR1:  adr1_q <= wdata;
          RID_ADR2:  adr2_q <= wdata;
          RID_SCLLO: scllo_q <= wdata;
          RID_SCLHI: sclhi_q <= wdata;
          RID_FPER:  fper_q <= wdata;
          RID_TXCTL: txctl_q <= wdata;
          RID_RXCTL: rxctl_q <= {wdata[7:6], wdata[5] | rxctl_q[5], wdata[4:0]};
          RID_TOUT:  tout_lo_q <= wdata[6:0];
          RID_FMODE: fmode_hi_q <= wdata[7:2];
          RID_FCTS:  fcts_ie_q <= wdata[3];
          default: ;
        endcase
      end
    end
  end

  // interrupt aggregation: {ber, negack, data-ready, nomatch, eob, rxthr, txthr, fifo}
  twi_irq #(.N_SRC(N_IRQ)) u_irq (
    .clk(clk), .rst(rst), .ien(ctl1_q[2]),
    .flag_v({st_flag[3], st_flag[2], seq_q[2], st_flag[0],
             aux_flag[AX_EOB], aux_flag[AX_RXT], aux_flag[AX_TXT], aux_flag[AX_FFE]}),
    .en_v({3'b111, ctl1_q[6], ctl1_q[3], rxctl_q[6], txctl_q[6], fcts_ie_q}),
    .irq(irq));

  // read multiplexer
  always_comb begin
    case (rid)
      RID_DATA:  rd_mux = rx_data;
      RID_STAT:  rd_mux = {st_flag[4], seq_q[2], st_flag[3], st_flag[2],
                           st_flag[1], st_flag[0], seq_q[1], seq_q[0]};
      RID_CSTAT: rd_mux = (RST_CSTAT & 8'hFD) | {6'b0, aux_flag[AX_BBS], 1'b0};
      RID_CTRL1: rd_mux = ctl1_q;
      RID_ADR1:  rd_mux = adr1_q;
      RID_CTRL2: rd_mux = ctl2_q;
      RID_ADR2:  rd_mux = adr2_q;
      RID_CTRL3: rd_mux = ctl3_q;
      RID_STAT2: rd_mux = {irq, 7'b0};
      RID_STAT3: rd_mux = {aux_flag[AX_EOB], 7'b0};
      RID_VER:   rd_mux = VER_VAL;
      RID_XADR:  rd_mux = xadr_q[xidx];
      RID_CTRL4: rd_mux = ctl4_q;
      RID_CTRL5: rd_mux = ctl5_q;
      RID_SCLLO: rd_mux = scllo_q;
      RID_FMODE: rd_mux = {fmode_hi_q, aux_flag[AX_FRD], fbusy_q};
      RID_SCLHI: rd_mux = sclhi_q;
      RID_FCTS:  rd_mux = {4'b0, fcts_ie_q, 1'b0, aux_flag[AX_FFE], 1'b0};
      RID_FPER:  rd_mux = fper_q;
      RID_TXCTL: rd_mux = txctl_q;
      RID_TOUT:  rd_mux = {aux_flag[AX_TMO], tout_lo_q};
      RID_TXSTS: rd_mux = {1'b0, aux_flag[AX_TXT], 6'b0};
      RID_RXSTS: rd_mux = {1'b0, aux_flag[AX_RXT], 6'b0};
      RID_RXCTL: rd_mux = rxctl_q;
      default:   rd_mux = '0;
    endcase
  end

  // registered read data and command strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0; start_stb <= 1'b0; stop_stb <= 1'b0; data_wr_stb <= 1'b0;
      data_rd_stb <= 1'b0; fifo_clr_stb <= 1'b0; tx_data <= '0;
    end else begin
      rdata        <= rd_en ? rd_mux : '0;
      start_stb    <= wr_en && (rid == RID_CTRL1) && wdata[0];
      stop_stb     <= wr_en && (rid == RID_CTRL1) && wdata[1];
      data_wr_stb  <= wr_en && (rid == RID_DATA);
      data_rd_stb  <= rd_en && (rid == RID_DATA);
      fifo_clr_stb <= wr_en && (rid == RID_FCTS) && wdata[6];
      if (wr_en && (rid == RID_DATA)) tx_data <= wdata;
    end
  end

  AST_START_STB: assert property (@(posedge clk) disable iff (rst)
    start_stb |-> $past(wr_en && (addr == OFS_CTRL1) && wdata[0])); // R3
  AST_STP_HW_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(st_flag[4]) |-> $past(evt_st[4])); // R2
  AST_VER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_VER) |=> (rdata == VER_VAL)); // R5
  AST_LINE_LVL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CTRL3) |=> (rdata[7:6] == 2'b11)); // R4
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_STAT2) |=> (rdata[7] == $past(irq))); // R7
  AST_TOUT_HW_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(aux_flag[AX_TMO]) |-> $past(evt_aux[AX_TMO])); // R8
  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rid == RID_NONE) |=> (rdata == 8'h00)); // R12
endmodule

// File: tb/tb_twi_ctl_regs.sv
`timescale 1ns/1ps
module tb_twi_ctl_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = 8'h3C;
  logic [4:0] evt_st = '0;
  logic [6:0] evt_aux = '0;
  logic [2:0] seq_lvl = '0;
  logic       fair_busy = 1'b0;
  logic [7:0] rdata, tx_data;
  logic       irq, start_stb, stop_stb, data_wr_stb, data_rd_stb, fifo_clr_stb;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  always #2.5 clk = ~clk;

  twi_ctl_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .evt_st(evt_st), .evt_aux(evt_aux),
    .seq_lvl(seq_lvl), .fair_busy(fair_busy), .rx_data(rx_data),
    .start_stb(start_stb), .stop_stb(stop_stb), .data_wr_stb(data_wr_stb),
    .data_rd_stb(data_rd_stb), .fifo_clr_stb(fifo_clr_stb), .tx_data(tx_data));

  // monitor: compare read data one cycle after each read
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q && !rst) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pst(input logic [4:0] v);
    @(negedge clk); evt_st = v;
    @(negedge clk); evt_st = '0;
  endtask

  task automatic paux(input logic [6:0] v);
    @(negedge clk); evt_aux = v;
    @(negedge clk); evt_aux = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R6 reset values
    chk({7'b0, irq}, 8'h00, "R6 irq after reset");
    chk({6'b0, start_stb, stop_stb}, 8'h00, "R6 strobes after reset");
    rd(5'h02, 8'h00, "R6 status");
    rd(5'h04, 8'h10, "R6 common status");
    rd(5'h06, 8'h00, "R6 ctrl1");
    rd(5'h0E, 8'hC0, "R6 ctrl3");
    rd(5'h1A, 8'h07, "R6 ctrl4");
    rd(5'h1F, 8'h81, "R5 version");
    rd(5'h18, 8'h00, "R6 status2");
    wr(5'h0E, 8'h20);
    rd(5'h14, 8'h3F, "R6 timeout");
    rd(5'h1E, 8'h01, "R6 rx control");
    rd(5'h1C, 8'h00, "R6 rx status");

    // R1 banking
    wr(5'h12, 8'h3C);
    wr(5'h0E, 8'h00);
    wr(5'h12, 8'h5A);
    rd(5'h12, 8'h5A, "R1 bank0 address reg");
    wr(5'h0E, 8'h20);
    rd(5'h12, 8'h3C, "R1 bank1 tx control");
    rd(5'h0E, 8'hE0, "R1 shared ctrl3 in bank1");

    // R12 undecoded offsets
    wr(5'h13, 8'hFF);
    rd(5'h13, 8'h00, "R12 bank1 hole read");
    rd(5'h01, 8'h00, "R12 odd offset read");
    wr(5'h0E, 8'h00);
    rd(5'h13, 8'h00, "R12 bank0 reg untouched");

    // R3 control 1
    wr(5'h06, 8'hFF);
    chk({6'b0, start_stb, stop_stb}, 8'h03, "R3 start+stop strobes");
    rd(5'h06, 8'hEC, "R3 kept bits");
    chk({7'b0, irq}, 8'h00, "R7 no source no irq");
    wr(5'h06, 8'h00);
    chk({7'b0, start_stb}, 8'h00, "R3 no strobe on zero");

    // R4 line-level bits
    wr(5'h0E, 8'h0F);
    rd(5'h0E, 8'hCF, "R4 line bits read-only");
    wr(5'h0E, 8'h00);

    // R5 read-only registers
    wr(5'h1F, 8'h00);
    rd(5'h1F, 8'h81, "R5 version ignores write");
    wr(5'h18, 8'hFF);
    rd(5'h18, 8'h00, "R5 status2 ignores write");

    // R2 write-one-to-clear
    pst(5'h1F);
    rd(5'h02, 8'hBC, "R2 all flags set");
    wr(5'h02, 8'h43);
    rd(5'h02, 8'hBC, "R2 zero/other bits no clear");
    wr(5'h02, 8'h24);
    rd(5'h02, 8'h98, "R2 selective clear");
    chk({7'b0, irq}, 8'h00, "R7 gated off");

    // R13 set and clear collide
    @(negedge clk); wr_en = 1'b1; addr = 5'h02; wdata = 8'h80; evt_st = 5'h10;
    @(negedge clk); wr_en = 1'b0; evt_st = '0;
    rd(5'h02, 8'h98, "R13 set wins over clear");
    wr(5'h02, 8'h98);
    rd(5'h02, 8'h00, "R2 cleared");

    // R7/R11 interrupt
    pst(5'h08);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 bus error without enable");
    wr(5'h06, 8'h04);
    chk({7'b0, irq}, 8'h00, "R11 one-cycle lag rise");
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 bus error irq");
    rd(5'h18, 8'h80, "R7 status2 mirror");
    wr(5'h02, 8'h20);
    chk({7'b0, irq}, 8'h01, "R11 one-cycle lag fall");
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 irq drops");
    pst(5'h01);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 nomatch needs enable");
    wr(5'h06, 8'h44);
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 nomatch irq");
    wr(5'h02, 8'h04);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 nomatch cleared");
    wr(5'h06, 8'h04);
    @(negedge clk); seq_lvl = 3'b100;
    idle(2);
    chk({7'b0, irq}, 8'h01, "R7 data-ready irq");
    rd(5'h02, 8'h40, "R7 data-ready status bit");
    @(negedge clk); seq_lvl = 3'b000;
    idle(2);
    chk({7'b0, irq}, 8'h00, "R7 data-ready gone");
    wr(5'h0E, 8'h20);
    paux(7'h02);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 rx threshold needs enable");
    rd(5'h1C, 8'h40, "R7 rx status flag");
    wr(5'h1E, 8'h41);
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 rx threshold irq");
    wr(5'h1C, 8'h40);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 rx threshold cleared");
    rd(5'h1C, 8'h00, "R2 rx status cleared");
    paux(7'h08);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 fifo flag needs enable");
    wr(5'h10, 8'h08);
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 fifo flag irq");
    rd(5'h10, 8'h0A, "R7 fifo status");
    wr(5'h10, 8'h0A);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 fifo flag cleared");
    rd(5'h10, 8'h08, "R7 fifo enable kept");
    wr(5'h10, 8'h00);
    paux(7'h01);
    rd(5'h19, 8'h80, "R7 end-of-busy flag");
    chk({7'b0, irq}, 8'h00, "R7 eob needs enable");
    wr(5'h06, 8'h0C);
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 eob irq");
    wr(5'h19, 8'h80);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 eob cleared");
    paux(7'h04);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 tx threshold needs enable");
    wr(5'h12, 8'h40);
    idle(1);
    chk({7'b0, irq}, 8'h01, "R7 tx threshold irq");
    wr(5'h1A, 8'h40);
    idle(1);
    chk({7'b0, irq}, 8'h00, "R7 tx threshold cleared");
    wr(5'h06, 8'h00);

    // R8 timeout flag
    wr(5'h14, 8'h80);
    rd(5'h14, 8'h00, "R8 write 1 never sets");
    paux(7'h20);
    rd(5'h14, 8'h80, "R8 hardware set");
    wr(5'h14, 8'h15);
    rd(5'h14, 8'h95, "R8 write 0 keeps 1");
    wr(5'h14, 8'h80);
    rd(5'h14, 8'h00, "R8 write 1 clears");

    // R10 rx control sticky bit
    wr(5'h1E, 8'h20);
    rd(5'h1E, 8'h20, "R10 last bit set");
    wr(5'h1E, 8'h00);
    rd(5'h1E, 8'h20, "R10 zero keeps last");
    wr(5'h1E, 8'h01);
    rd(5'h1E, 8'h21, "R10 plain bits");

    // R14 fifo flush
    wr(5'h10, 8'h40);
    chk({7'b0, fifo_clr_stb}, 8'h01, "R14 flush strobe");
    rd(5'h10, 8'h00, "R14 flush bit reads 0");

    // R2 common status bus flag
    paux(7'h40);
    rd(5'h04, 8'h12, "R2 common status flag");
    wr(5'h04, 8'hFF);
    rd(5'h04, 8'h10, "R2 common status clear, others RO");

    // R9 arbitration-mode register
    wr(5'h0E, 8'h00);
    wr(5'h1D, 8'hFF);
    rd(5'h1D, 8'hFC, "R9 busy and ready not writable");
    @(negedge clk); fair_busy = 1'b1;
    idle(1);
    rd(5'h1D, 8'hFD, "R9 busy mirror");
    paux(7'h10);
    rd(5'h1D, 8'hFF, "R9 ready set");
    wr(5'h1D, 8'hFE);
    rd(5'h1D, 8'hFD, "R9 ready write-1 clear");

    // R14 data register
    wr(5'h00, 8'hA5);
    chk({7'b0, data_wr_stb}, 8'h01, "R14 data write strobe");
    chk(tx_data, 8'hA5, "R14 tx byte");
    rd(5'h00, 8'h3C, "R14 data read");
    chk({7'b0, data_rd_stb}, 8'h01, "R14 data read strobe");

    idle(2);
    chk(exp_q.size(), 8'h00, "scoreboard drained");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule